// File: doc/BRIEF.md
# Hyperframe Control Word Inserter

This block sits in the transmit path of a fronthaul radio link. It builds the control word of every basic frame. A strobe marks each new basic frame. The block tracks the frame position inside a 256-frame hyperframe, the hyperframe number inside a 150-hyperframe cycle, and a 12-bit count of completed cycles. From these it decides what goes into the control word:

- a fixed protocol field,
- a byte taken from a programmable per-position table, or
- the control data supplied by the upstream logic, unchanged.

Software programs the table through a small register port. It first selects a position with an index write, then writes that position's byte and enable bit. Table writes are staged in a shadow copy, so the live table only changes at a hyperframe edge. A global enable, which takes effect immediately, gates every table override. The word is a configurable number of bytes wide, and each byte has a flag marking it as a K character.

Top module: `cw_inserter`

## Requirements
- R1: `pos` resets to 0 and advances by one, modulo 256, on every clock edge where `frame_stb` is high. It holds otherwise.
- R2: `hfn` runs from 0 to 149. It advances when a strobe arrives at position 255 and wraps to 0 after 149. `bfn` is 12 bits wide and advances by one when `hfn` wraps. Both reset to 0.
- R3: At position 0, byte 0 of `cw_out` is 0xBC and `cw_k[0]` is 1. Every other byte of that word is 0x50. `cw_k` is all zero at every other position.
- R4: The fixed fields below are placed in byte 0, zero-extended. All other bytes of those words are 0.
  - position 64: `hfn`
  - position 66: `hdlc_rate`
  - position 128: `bfn[7:0]`
  - position 192: `bfn[11:8]`
  - position 194: `eth_ptr`
- R5: Register writes happen when `reg_we` is high, and `reg_sel` chooses the target:
  - `reg_sel` = 0 loads the index from `reg_wdata[7:0]`.
  - `reg_sel` = 1 writes the shadow entry at the current index. Bit 8 is the entry enable and bits 7:0 are the byte.
  - `reg_sel` = 2 sets the global insert enable from bit 0, and the change shows on the output at once.
  - `reg_sel` = 3 has no effect.
- R6: At a position with no fixed field, the entry byte is repeated into every byte of `cw_out` only when both the entry enable and the global enable are 1. Otherwise `cw_out` equals `cw_in`.
- R7: An entry write reaches the live table at the next hyperframe edge. That edge is the strobe at position 255. A write made in the same cycle as that strobe is included.
- R8: At positions 0, 64, 66, 128, 192 and 194, the fixed field wins over an enabled table entry.
- R9: After reset every table entry is disabled, the global enable is 0, and the index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | Advance to the next basic frame |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 index, 1 entry, 2 control, 3 unused |
| reg_wdata | input | 9 | Register write data |
| hdlc_rate | input | 8 | Value for the HDLC rate field |
| eth_ptr | input | 8 | Value for the Ethernet start pointer field |
| cw_in | input | 8*BYTES | Upstream control data |
| cw_out | output | 8*BYTES | Outgoing control word |
| cw_k | output | BYTES | Per-byte K-character flag |
| pos | output | 8 | Control word position within the hyperframe |
| hfn | output | 8 | Hyperframe number |
| bfn | output | 12 | Cycle count of hyperframes |

## Verification
The assertions assume that `frame_stb` is the only thing that moves the counters. They also assume that the live table changes only on a hyperframe edge, so any cycle without a strobe must leave the current entry and all counters stable. The stimulus keeps register writes in cycles without a strobe, except for one deliberate write in the same cycle as the strobe at position 255. The bench steps through four full hyperframes position by position, comparing each word against a model kept in the bench. It then runs the strobe continuously across the 150-hyperframe wrap.

// File: rtl/cw_inserter.sv
module cw_inserter #(
  parameter int BYTES    = 2,
  parameter int HF_COUNT = 150,
  parameter int BFN_W    = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_stb,
  input  logic               reg_we,
  input  logic [1:0]         reg_sel,
  input  logic [8:0]         reg_wdata,
  input  logic [7:0]         hdlc_rate,
  input  logic [7:0]         eth_ptr,
  input  logic [8*BYTES-1:0] cw_in,
  output logic [8*BYTES-1:0] cw_out,
  output logic [BYTES-1:0]   cw_k,
  output logic [7:0]         pos,
  output logic [7:0]         hfn,
  output logic [BFN_W-1:0]   bfn
);
  localparam int W    = 8 * BYTES;
  localparam int NPOS = 256;
  localparam logic [7:0] X_SYNC = 8'd0,   X_HFN    = 8'd64,  X_HDLC = 8'd66;
  localparam logic [7:0] X_BLO  = 8'd128, X_BHI    = 8'd192, X_ETH  = 8'd194;
  localparam logic [7:0] K_COMMA = 8'hBC, D_FILL = 8'h50;
  localparam logic [7:0] HF_LAST = 8'(HF_COUNT - 1);

  logic [7:0] idx_q;
  logic       ins_en_q;
  logic [8:0] shadow [NPOS];
  logic [8:0] active [NPOS];

  wire boundary = frame_stb && (pos == 8'hFF);
  wire data_we  = reg_we && (reg_sel == 2'd1);
  wire [8:0] ent = active[pos];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos      <= '0;
      hfn      <= '0;
      bfn      <= '0;
      idx_q    <= '0;
      ins_en_q <= 1'b0;
    end else begin
      if (reg_we && reg_sel == 2'd0) idx_q    <= reg_wdata[7:0];
      if (reg_we && reg_sel == 2'd2) ins_en_q <= reg_wdata[0];
      if (frame_stb) pos <= pos + 8'd1;
      if (boundary) begin
        if (hfn == HF_LAST) begin
          hfn <= '0;
          bfn <= bfn + 1'b1;
        end else begin
          hfn <= hfn + 8'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPOS; i++) begin
        shadow[i] <= '0;
        active[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NPOS; i++) begin
        if (data_we && idx_q == 8'(i)) shadow[i] <= reg_wdata;
        if (boundary) active[i] <= (data_we && idx_q == 8'(i)) ? reg_wdata : shadow[i];
      end
    end
  end

  always_comb begin
    cw_out = cw_in;
    cw_k   = '0;
    case (pos)
      X_SYNC: begin
        cw_out      = {BYTES{D_FILL}};
        cw_out[7:0] = K_COMMA;
        cw_k[0]     = 1'b1;
      end
      X_HFN:  cw_out = W'(hfn);
      X_HDLC: cw_out = W'(hdlc_rate);
      X_BLO:  cw_out = W'(bfn[7:0]);
      X_BHI:  cw_out = W'(bfn[BFN_W-1:8]);
      X_ETH:  cw_out = W'(eth_ptr);
      default: if (ins_en_q && ent[8]) cw_out = {BYTES{ent[7:0]}};
    endcase
  end

  assert_k_sync_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_k != '0) |-> ($onehot0(cw_k) && pos == X_SYNC && cw_out[7:0] == K_COMMA));

  assert_pos_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> pos == $past(pos) + 8'd1);

  assert_hold_no_stb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> ($stable(pos) && $stable(hfn) && $stable(bfn)));

  assert_hfn_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hfn <= HF_LAST);

  assert_bfn_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && hfn == HF_LAST) |=> (hfn == 8'd0 && bfn == $past(bfn) + 1'b1));

  assert_tbl_staged_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(ent));
endmodule

// File: tb/cw_inserter_test.sv
module cw_inserter_test;
  localparam int BYTES = 2;
  localparam int W = 8 * BYTES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_stb = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [8:0] reg_wdata = '0;
  logic [7:0] hdlc_rate = 8'h2A, eth_ptr = 8'h15;
  logic [W-1:0] cw_in = '0;
  logic [W-1:0] cw_out;
  logic [BYTES-1:0] cw_k;
  logic [7:0] pos, hfn;
  logic [11:0] bfn;

  cw_inserter #(.BYTES(BYTES)) uut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .hdlc_rate(hdlc_rate),
    .eth_ptr(eth_ptr), .cw_in(cw_in), .cw_out(cw_out), .cw_k(cw_k),
    .pos(pos), .hfn(hfn), .bfn(bfn));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] m_pos = 0, m_hfn = 0, m_idx = 0;
  logic [11:0] m_bfn = 0;
  logic m_en = 0;
  logic [8:0] m_sh [256];
  logic [8:0] m_ac [256];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pos=%0d hfn=%0d actual=%h expected=%h", req, m_pos, m_hfn, act, exp);
    end
  endtask

  task automatic model_wr(input logic [1:0] sel, input logic [8:0] d);
    case (sel)
      2'd0: m_idx = d[7:0];
      2'd1: m_sh[m_idx] = d;
      2'd2: m_en = d[0];
      default: ;
    endcase
  endtask

  task automatic model_adv();
    if (m_pos == 8'hFF) begin
      for (int i = 0; i < 256; i++) m_ac[i] = m_sh[i];
      if (m_hfn == 8'd149) begin m_hfn = 0; m_bfn++; end
      else m_hfn++;
    end
    m_pos++;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [8:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    model_wr(sel, d);
  endtask

  task automatic frame(input logic do_wr, input logic [1:0] sel, input logic [8:0] d);
    logic [W-1:0] e;
    logic [BYTES-1:0] ek;
    @(negedge clk);
    cw_in = {~m_pos, m_pos ^ m_hfn ^ 8'h3C};
    #1;
    e = cw_in; ek = '0;
    case (m_pos)
      8'd0:   begin e = {8'h50, 8'hBC}; ek = 2'b01; end
      8'd64:  e = W'(m_hfn);
      8'd66:  e = W'(hdlc_rate);
      8'd128: e = W'(m_bfn[7:0]);
      8'd192: e = W'(m_bfn[11:8]);
      8'd194: e = W'(eth_ptr);
      default: if (m_en && m_ac[m_pos][8]) e = {BYTES{m_ac[m_pos][7:0]}};
    endcase
    if (m_pos == 0) check("R3 sync word", 32'(cw_out), 32'(e));
    else if (m_pos == 64 || m_pos == 66 || m_pos == 128 || m_pos == 192 || m_pos == 194)
      check("R4/R8 fixed field", 32'(cw_out), 32'(e));
    else check("R6/R7 table or pass", 32'(cw_out), 32'(e));
    check("R3 k flags", 32'(cw_k), 32'(ek));
    check("R1 position", 32'(pos), 32'(m_pos));
    frame_stb = 1;
    if (do_wr) begin reg_we = 1; reg_sel = sel; reg_wdata = d; end
    @(negedge clk);
    frame_stb = 0; reg_we = 0;
    if (do_wr) model_wr(sel, d);
    model_adv();
  endtask

  task automatic run_fast(input int n);
    @(negedge clk);
    frame_stb = 1;
    repeat (n) @(posedge clk);
    #1 frame_stb = 0;
    for (int i = 0; i < n; i++) model_adv();
    @(negedge clk);
    check("R1 pos after run", 32'(pos), 32'(m_pos));
    check("R2 hfn after run", 32'(hfn), 32'(m_hfn));
    check("R2 bfn after run", 32'(bfn), 32'(m_bfn));
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin m_sh[i] = 0; m_ac[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R9 reset pos", 32'(pos), 0);
    check("R9 reset hfn", 32'(hfn), 0);
    check("R9 reset bfn", 32'(bfn), 0);
    // R5: program shadow entries and the global enable
    wr(2'd0, 9'd5);   wr(2'd1, {1'b1, 8'hA5});
    wr(2'd0, 9'd7);   wr(2'd1, {1'b0, 8'h33});
    wr(2'd0, 9'd64);  wr(2'd1, {1'b1, 8'hEE});
    wr(2'd0, 9'd255); wr(2'd1, {1'b1, 8'h5A});
    wr(2'd2, 9'd1);
    for (int hf = 0; hf < 4; hf++) begin
      for (int p = 0; p < 256; p++) begin
        if (hf == 1 && p == 100) begin wr(2'd0, 9'd5); wr(2'd1, {1'b1, 8'h11}); end
        if (hf == 2 && p == 130) wr(2'd2, 9'd0);
        if (hf == 2 && p == 131) wr(2'd3, 9'h1FF);
        if (hf == 2 && p == 250) wr(2'd0, 9'd7);
        if (hf == 3 && p == 0) wr(2'd2, 9'd1);
        if (hf == 2 && p == 255) frame(1'b1, 2'd1, {1'b1, 8'h77});
        else frame(1'b0, 2'd0, 9'd0);
      end
    end
    run_fast(145 * 256);
    check("R2 hfn reaches 149", 32'(hfn), 149);
    run_fast(256 + 128);
    check("R2 hfn wrapped", 32'(hfn), 0);
    check("R2 bfn advanced", 32'(bfn), 1);
    check("R4 bfn low field", 32'(cw_out), 32'h0001);
    for (int p = 0; p < 70; p++) frame(1'b0, 2'd0, 9'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule